// File: doc/BRIEF.md
# Sampling Front-End Register Controller

This block is the register-mapped control and status point for a 16-channel sampling front end. A host talks to it over a simple address/strobe bus. Through that bus it sets a gain code, a channel or scan limit, the conversion trigger source and the interrupt sources. It pops conversion results from a deep sample FIFO and acknowledges interrupts. The block issues a one-cycle conversion request, with a channel number, to an external converter. The converter's 16-bit results come back on a sample strobe and are queued in the FIFO.

Conversions start in one of three ways. In software mode, a write to a trigger address starts one conversion. The other two sources are a pacer tick pulse and an external trigger pulse, each enabled by its own control bit. With auto-scan on, consecutive conversions step from channel 0 up to the programmed limit and then wrap. The FIFO status flags in the status byte are active-low, in the manner of legacy acquisition cards. The FIFO is flushed by toggling its enable bit low, high and low on three consecutive interrupt-control writes. A level interrupt latches on the selected events and stays set until the host writes the clear address.

Top module: `acq_regctl`

## Requirements
- R1: After reset the status byte (address 0x08) reads 0x60, `irq` is 0 and `conv_req` is 0.
- R2: A write to 0x08 stores the gain code from data bits 2:0, and status bits 2:0 read it back unchanged.
- R3: Reads of 0x00 return queued samples oldest first and remove them. Status bit 4 reads 1 while at least one sample is queued and 0 when the FIFO is empty.
- R4: Status bit 5 reads 0 while 512 or more samples (half of the 1024-word depth) are queued, and 1 otherwise.
- R5: Status bit 6 reads 0 once the FIFO has held 1024 samples. A sample arriving while the FIFO is full is discarded. Bit 6 stays 0 until the FIFO is flushed, even after reads.
- R6: The FIFO is flushed only when three consecutive writes to 0x0C carry data bit 2 as 0, then 1, then 0. A write of 0 that does not complete this pattern leaves the queued samples in place.
- R7: Control byte 0x0A has three enables: bit 1 enables the pacer tick, bit 2 enables the external pulse, and with both clear a write to 0x0E starts a conversion. A trigger from a source that is not enabled produces no `conv_req`.
- R8: With 0x0A bit 0 set, consecutive conversions request channels 0, 1, …, L and then 0 again, where L is the value in channel register 0x06. A write to 0x06 or 0x0A restarts the sequence at 0.
- R9: With 0x0A bit 0 clear, every conversion requests the channel held in 0x06, and reads of 0x06 return that value.
- R10: A read of 0x0A returns the trigger enables in bits 2:0 and the interrupt-control bits (written at 0x0C) in bits 6:4.
- R11: Interrupt source 0 is a sample arrival when 0x0C bit 0 is 0. When that bit is 1, it is the FIFO level reaching 512.
- R12: Interrupt source 1 is a pacer tick when 0x0C bit 1 is 0 and an external pulse when it is 1. `irq` is set by either source, holds its level, and clears only on a write to 0x48.
- R13: Status bit 7 follows the `conv_busy` input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 7 | Register address |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe; a read of 0x00 pops the FIFO at the clock edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 16 | Read data, valid while `bus_rd` is high |
| smp_valid | input | 1 | Converter result strobe |
| smp_data | input | 16 | Converter result |
| conv_busy | input | 1 | Converter busy level, shown in status |
| pacer_tick | input | 1 | Pacer tick pulse |
| ext_trig | input | 1 | External trigger pulse |
| conv_req | output | 1 | One-cycle conversion request |
| conv_chan | output | 4 | Channel for the current request |
| irq | output | 1 | Latched level interrupt |

## Verification
The bench fills the FIFO to exactly 511 samples and then to 512, checking both the half flag and the crossing interrupt. A design that compares with the wrong bound would flip the flag or raise the interrupt one sample early or late. It then overfills with a marker value and drains all 1024 samples. A design that overwrote on full would return the marker, and one that derived the full flag from the live level would clear it after the first read. The flush pattern is driven once with a leading 0 that should not flush and once complete, so a detector that fires on any 1-to-0 edge loses data. The scan wrap and the ignored trigger sources are checked at `conv_req`/`conv_chan`, where an off-by-one limit compare or a missing source gate shows directly.

// File: rtl/acq_regctl_pkg.sv
package acq_regctl_pkg;

   typedef enum logic [6:0] {
      A_FIFO   = 7'h00,
      A_CHAN   = 7'h06,
      A_RANGE  = 7'h08,
      A_TRIG   = 7'h0A,
      A_INTC   = 7'h0C,
      A_SWTRIG = 7'h0E,
      A_ICLR   = 7'h48
   } reg_addr_e;

   typedef struct packed {
      logic ext_en;
      logic pacer_en;
      logic auto_scan;
   } trig_ctl_t;

   typedef struct packed {
      logic fifo_en;
      logic src1_ext;
      logic src0_half;
   } int_ctl_t;

endpackage

// File: rtl/acq_sample_fifo.sv
module acq_sample_fifo #(
   parameter int unsigned DATA_W = 16,
   parameter int unsigned DEPTH  = 1024
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              push,
   input  logic [DATA_W-1:0] wdata,
   input  logic              pop,
   output logic [DATA_W-1:0] rdata,
   output logic              nonempty,
   output logic              half,
   output logic              full_seen,
   output logic              half_evt
);
   localparam int unsigned AW = $clog2(DEPTH);
   localparam logic [AW:0] CNT_FULL = (AW+1)'(DEPTH);
   localparam logic [AW:0] CNT_HALF = (AW+1)'(DEPTH / 2);

   generate
      if (DEPTH < 4 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("acq_sample_fifo: DEPTH must be a power of two of at least 4");
      end
   endgenerate

   logic [DATA_W-1:0] mem [DEPTH];
   logic [AW-1:0]     wp, rp;
   logic [AW:0]       cnt;
   logic              push_ok, pop_ok;

   assign push_ok  = push && (cnt != CNT_FULL);
   assign pop_ok   = pop && (cnt != '0);
   assign rdata    = mem[rp];
   assign nonempty = (cnt != '0);
   assign half     = (cnt >= CNT_HALF);
   assign half_evt = push_ok && !pop_ok && (cnt == CNT_HALF - 1'b1);

   always_ff @(posedge clk) begin
      if (push_ok) mem[wp] <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp        <= '0;
         rp        <= '0;
         cnt       <= '0;
         full_seen <= 1'b0;
      end else if (clr) begin
         wp        <= '0;
         rp        <= '0;
         cnt       <= '0;
         full_seen <= 1'b0;
      end else begin
         if (push_ok) wp <= wp + 1'b1;
         if (pop_ok)  rp <= rp + 1'b1;
         case ({push_ok, pop_ok})
            2'b10:   cnt <= cnt + 1'b1;
            2'b01:   cnt <= cnt - 1'b1;
            default: cnt <= cnt;
         endcase
         if (push_ok && !pop_ok && cnt == CNT_FULL - 1'b1) full_seen <= 1'b1;
      end
   end

   // R5: level never exceeds depth
   p_level_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CNT_FULL);
   // R5: an arrival on a full FIFO leaves it full and is dropped
   p_drop_when_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt == CNT_FULL && push && !pop && !clr) |=> (cnt == CNT_FULL));
   // R5: full indication is sticky until a flush
   p_full_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (full_seen && !clr) |=> full_seen);
   // R6: a flush empties the queue
   p_flush_empties_r6: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (cnt == '0));

endmodule

// File: rtl/acq_scan_seq.sv
module acq_scan_seq #(
   parameter int unsigned CHAN_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              restart,
   input  logic              step,
   input  logic              auto_scan,
   input  logic [CHAN_W-1:0] chan_sel,
   output logic [CHAN_W-1:0] chan_now
);
   logic [CHAN_W-1:0] cur;

   assign chan_now = auto_scan ? cur : chan_sel;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 cur <= '0;
      else if (restart)           cur <= '0;
      else if (step && auto_scan) cur <= (cur >= chan_sel) ? '0 : cur + 1'b1;
   end

   // R8: scan position stays within the programmed limit
   p_scan_in_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
      auto_scan |-> (cur <= chan_sel));
   // R8: stepping from the limit wraps to channel 0
   p_scan_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (step && auto_scan && !restart && cur == chan_sel) |=> (cur == '0));

endmodule

// File: rtl/acq_irq_ctl.sv
module acq_irq_ctl #(
   parameter bit SET_WINS = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic src0_half,
   input  logic src1_ext,
   input  logic eoc_evt,
   input  logic half_evt,
   input  logic tick_evt,
   input  logic ext_evt,
   input  logic clr,
   output logic irq
);
   logic evt, irq_nx;

   assign evt = (src0_half ? half_evt : eoc_evt) | (src1_ext ? ext_evt : tick_evt);

   generate
      if (SET_WINS) begin : g_set_wins
         assign irq_nx = evt | (irq & ~clr);
      end else begin : g_clr_wins
         assign irq_nx = (evt | irq) & ~clr;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq <= 1'b0;
      else        irq <= irq_nx;
   end

   // R12: level holds until the clear address is written
   p_irq_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !clr) |=> irq);
   // R12: a clear with no new event drops the level
   p_irq_clear_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !eoc_evt && !half_evt && !tick_evt && !ext_evt) |=> !irq);

endmodule

// File: rtl/acq_regctl.sv
module acq_regctl
   import acq_regctl_pkg::*;
#(
   parameter int unsigned DATA_W       = 16,
   parameter int unsigned CHAN_W       = 4,
   parameter int unsigned GAIN_W       = 3,
   parameter int unsigned FIFO_DEPTH   = 1024,
   parameter bit          IRQ_SET_WINS = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [6:0]        bus_addr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [7:0]        bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              smp_valid,
   input  logic [DATA_W-1:0] smp_data,
   input  logic              conv_busy,
   input  logic              pacer_tick,
   input  logic              ext_trig,
   output logic              conv_req,
   output logic [CHAN_W-1:0] conv_chan,
   output logic              irq
);
   generate
      if (GAIN_W < 1 || GAIN_W > 3) begin : g_bad_gain
         $error("acq_regctl: GAIN_W must be 1 to 3");
      end
      if (CHAN_W < 1 || CHAN_W > 8) begin : g_bad_chan
         $error("acq_regctl: CHAN_W must be 1 to 8");
      end
      if (DATA_W < 8) begin : g_bad_data
         $error("acq_regctl: DATA_W must be at least 8");
      end
   endgenerate

   trig_ctl_t         trig_q;
   int_ctl_t          intc_q;
   logic [GAIN_W-1:0] gain_q;
   logic [CHAN_W-1:0] chan_q;
   logic [1:0]        en_hist;

   logic wr_chan, wr_range, wr_trig, wr_intc, wr_sw, wr_iclr, rd_pop;
   logic fifo_clr, sw_mode, fire;
   logic fifo_ne, fifo_half, fifo_full, fifo_hevt;
   logic [DATA_W-1:0] fifo_q;
   logic [CHAN_W-1:0] seq_chan;
   logic unused_wbits;

   assign unused_wbits = ^bus_wdata;

   assign wr_chan  = bus_wr && bus_addr == A_CHAN;
   assign wr_range = bus_wr && bus_addr == A_RANGE;
   assign wr_trig  = bus_wr && bus_addr == A_TRIG;
   assign wr_intc  = bus_wr && bus_addr == A_INTC;
   assign wr_sw    = bus_wr && bus_addr == A_SWTRIG;
   assign wr_iclr  = bus_wr && bus_addr == A_ICLR;
   assign rd_pop   = bus_rd && bus_addr == A_FIFO;

   // flush on enable bit history 0 -> 1 -> 0 across three interrupt-control writes
   assign fifo_clr = wr_intc && !en_hist[1] && en_hist[0] && !bus_wdata[2];

   assign sw_mode = !trig_q.pacer_en && !trig_q.ext_en;
   assign fire    = (sw_mode && wr_sw) || (trig_q.pacer_en && pacer_tick) ||
                    (trig_q.ext_en && ext_trig);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         trig_q  <= '0;
         intc_q  <= '0;
         gain_q  <= '0;
         chan_q  <= '0;
         en_hist <= 2'b11;
      end else begin
         if (wr_trig)  trig_q <= trig_ctl_t'(bus_wdata[2:0]);
         if (wr_range) gain_q <= bus_wdata[GAIN_W-1:0];
         if (wr_chan)  chan_q <= bus_wdata[CHAN_W-1:0];
         if (wr_intc) begin
            intc_q  <= int_ctl_t'(bus_wdata[2:0]);
            en_hist <= {en_hist[0], bus_wdata[2]};
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         conv_req  <= 1'b0;
         conv_chan <= '0;
      end else begin
         conv_req <= fire;
         if (fire) conv_chan <= seq_chan;
      end
   end

   acq_scan_seq #(.CHAN_W(CHAN_W)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .restart   (wr_chan || wr_trig),
      .step      (fire),
      .auto_scan (trig_q.auto_scan),
      .chan_sel  (chan_q),
      .chan_now  (seq_chan)
   );

   acq_sample_fifo #(.DATA_W(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (fifo_clr),
      .push      (smp_valid),
      .wdata     (smp_data),
      .pop       (rd_pop),
      .rdata     (fifo_q),
      .nonempty  (fifo_ne),
      .half      (fifo_half),
      .full_seen (fifo_full),
      .half_evt  (fifo_hevt)
   );

   acq_irq_ctl #(.SET_WINS(IRQ_SET_WINS)) u_irq (
      .clk       (clk),
      .rst_n     (rst_n),
      .src0_half (intc_q.src0_half),
      .src1_ext  (intc_q.src1_ext),
      .eoc_evt   (smp_valid),
      .half_evt  (fifo_hevt),
      .tick_evt  (pacer_tick),
      .ext_evt   (ext_trig),
      .clr       (wr_iclr),
      .irq       (irq)
   );

   logic [7:0] stat_b, trig_b;

   always_comb begin
      stat_b              = '0;
      stat_b[7]           = conv_busy;
      stat_b[6]           = ~fifo_full;
      stat_b[5]           = ~fifo_half;
      stat_b[4]           = fifo_ne;
      stat_b[GAIN_W-1:0]  = gain_q;
      trig_b              = '0;
      trig_b[6:4]         = intc_q;
      trig_b[2:0]         = trig_q;
   end

   always_comb begin
      bus_rdata = '0;
      if (bus_rd) begin
         case (bus_addr)
            A_FIFO:  bus_rdata = fifo_ne ? fifo_q : '0;
            A_CHAN:  bus_rdata = DATA_W'(chan_q);
            A_RANGE: bus_rdata = DATA_W'(stat_b);
            A_TRIG:  bus_rdata = DATA_W'(trig_b);
            default: bus_rdata = '0;
         endcase
      end
   end

   // R7: a software write outside software mode starts nothing
   p_sw_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_sw && !sw_mode && !pacer_tick && !ext_trig) |=> !conv_req);
   // R7: a pacer tick with pacer and external both disabled starts nothing
   p_tick_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (pacer_tick && !trig_q.pacer_en && !trig_q.ext_en && !wr_sw) |=> !conv_req);
   // R9: without auto-scan the request carries the channel register
   p_fixed_chan_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && !trig_q.auto_scan) |=> (conv_chan == $past(chan_q)));

endmodule

// File: tb/sim_acq_regctl.sv
`timescale 1ns/1ps
module sim_acq_regctl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [6:0]  bus_addr = '0;
   logic        bus_wr = 1'b0, bus_rd = 1'b0;
   logic [7:0]  bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic        smp_valid = 1'b0;
   logic [15:0] smp_data = '0;
   logic        conv_busy = 1'b0, pacer_tick = 1'b0, ext_trig = 1'b0;
   logic        conv_req;
   logic [3:0]  conv_chan;
   logic        irq;

   int checks = 0, failures = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   acq_regctl u0 (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .smp_valid(smp_valid),
      .smp_data(smp_data), .conv_busy(conv_busy), .pacer_tick(pacer_tick),
      .ext_trig(ext_trig), .conv_req(conv_req), .conv_chan(conv_chan), .irq(irq)
   );

   // register vectors: write address/data, read address, mask, expected
   localparam int NV = 8;
   localparam logic [6:0] TV_WA [NV] = '{7'h08, 7'h08, 7'h0C, 7'h0A, 7'h0A, 7'h0C, 7'h06, 7'h08};
   localparam logic [7:0] TV_WD [NV] = '{8'h03, 8'h04, 8'h03, 8'h05, 8'h00, 8'h00, 8'h09, 8'h00};
   localparam logic [6:0] TV_RA [NV] = '{7'h08, 7'h08, 7'h0A, 7'h0A, 7'h0A, 7'h0A, 7'h06, 7'h08};
   localparam logic [7:0] TV_MK [NV] = '{8'h07, 8'h07, 8'hF0, 8'hFF, 8'h0F, 8'hFF, 8'h0F, 8'hF7};
   localparam logic [7:0] TV_EX [NV] = '{8'h03, 8'h04, 8'h30, 8'h35, 8'h00, 8'h00, 8'h09, 8'h60};

   task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [6:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [6:0] a, output logic [15:0] d);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic tick();
      @(negedge clk); pacer_tick = 1'b1;
      @(negedge clk); pacer_tick = 1'b0;
   endtask

   task automatic ext();
      @(negedge clk); ext_trig = 1'b1;
      @(negedge clk); ext_trig = 1'b0;
   endtask

   task automatic push_n(input logic [15:0] base, input int n);
      @(negedge clk);
      for (int i = 0; i < n; i++) begin
         smp_data = base + 16'(i); smp_valid = 1'b1;
         @(negedge clk);
      end
      smp_valid = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++; failures++;
         $display("FAIL watchdog (all requirements) actual=hung expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      logic [15:0] d;
      int ref_ch, bad;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      rd(7'h08, d);
      chk("R1 status after reset", d, 16'h0060);
      chk("R1 irq after reset", 16'(irq), 16'h0);
      chk("R1 conv_req after reset", 16'(conv_req), 16'h0);

      // table of register vectors (R2, R9, R10)
      for (int v = 0; v < NV; v++) begin
         wr(TV_WA[v], TV_WD[v]);
         rd(TV_RA[v], d);
         if (TV_RA[v] == 7'h0A)      chk("R10 trigger readback", d & 16'(TV_MK[v]), 16'(TV_EX[v]));
         else if (TV_RA[v] == 7'h06) chk("R9 channel readback", d & 16'(TV_MK[v]), 16'(TV_EX[v]));
         else                        chk("R2 gain readback", d & 16'(TV_MK[v]), 16'(TV_EX[v]));
      end

      // R13: busy mirror
      conv_busy = 1'b1;
      rd(7'h08, d);
      chk("R13 busy high", d & 16'h0080, 16'h0080);
      conv_busy = 1'b0;
      rd(7'h08, d);
      chk("R13 busy low", d & 16'h0080, 16'h0000);

      // software mode, fixed channel 9 (R7, R9)
      wr(7'h0E, 8'h00);
      chk("R9 sw trigger chan", 16'({conv_req, conv_chan}), 16'h19);
      wr(7'h0E, 8'h00);
      chk("R9 repeat chan fixed", 16'({conv_req, conv_chan}), 16'h19);
      tick();
      chk("R7 tick ignored in sw mode", 16'(conv_req), 16'h0);
      ext();
      chk("R7 ext ignored in sw mode", 16'(conv_req), 16'h0);

      // pacer mode
      wr(7'h0A, 8'h02);
      tick();
      chk("R7 pacer tick converts", 16'({conv_req, conv_chan}), 16'h19);
      wr(7'h0E, 8'h00);
      chk("R7 sw write ignored in pacer mode", 16'(conv_req), 16'h0);

      // R8: auto-scan with pacer, limit 2
      wr(7'h06, 8'h02);
      wr(7'h0A, 8'h03);
      ref_ch = 0; bad = 0;
      for (int k = 0; k < 7; k++) begin
         tick();
         if ({conv_req, conv_chan} !== {1'b1, 4'(ref_ch)}) begin
            bad++;
            $display("FAIL R8 scan step %0d actual=%h expected=%h", k, {conv_req, conv_chan}, {1'b1, 4'(ref_ch)});
         end
         ref_ch = (ref_ch == 2) ? 0 : ref_ch + 1;
      end
      checks++; if (bad != 0) failures++;

      // R8: auto-scan with external trigger, limit 3
      wr(7'h06, 8'h03);
      wr(7'h0A, 8'h05);
      ref_ch = 0; bad = 0;
      for (int k = 0; k < 5; k++) begin
         ext();
         if ({conv_req, conv_chan} !== {1'b1, 4'(ref_ch)}) begin
            bad++;
            $display("FAIL R8 ext scan step %0d actual=%h expected=%h", k, {conv_req, conv_chan}, {1'b1, 4'(ref_ch)});
         end
         ref_ch = (ref_ch == 3) ? 0 : ref_ch + 1;
      end
      checks++; if (bad != 0) failures++;
      tick();
      chk("R7 tick ignored in ext mode", 16'(conv_req), 16'h0);

      // R12: interrupt source 1
      wr(7'h0C, 8'h00);
      wr(7'h48, 8'h00);
      chk("R12 clear", 16'(irq), 16'h0);
      tick();
      chk("R12 tick sets irq", 16'(irq), 16'h1);
      repeat (3) @(negedge clk);
      chk("R12 irq sticky", 16'(irq), 16'h1);
      wr(7'h48, 8'h00);
      chk("R12 clear after tick", 16'(irq), 16'h0);
      wr(7'h0C, 8'h02);
      tick();
      chk("R12 tick ignored when ext selected", 16'(irq), 16'h0);
      ext();
      chk("R12 ext sets irq", 16'(irq), 16'h1);
      wr(7'h48, 8'h00);

      // R11 end-of-conversion source, R3 pop
      push_n(16'hBEEF, 1);
      chk("R11 sample arrival sets irq", 16'(irq), 16'h1);
      wr(7'h48, 8'h00);
      rd(7'h08, d);
      chk("R3 data available", d & 16'h0010, 16'h0010);
      rd(7'h00, d);
      chk("R3 pop value", d, 16'hBEEF);
      rd(7'h08, d);
      chk("R3 empty after pop", d & 16'h0010, 16'h0000);

      // R4, R5, R11 half-full source
      wr(7'h0C, 8'h03);
      wr(7'h48, 8'h00);
      push_n(16'h1000, 511);
      rd(7'h08, d);
      chk("R4 half flag at 511", d & 16'h0020, 16'h0020);
      chk("R11 no irq below half", 16'(irq), 16'h0);
      push_n(16'h1000 + 16'd511, 1);
      chk("R11 irq at half", 16'(irq), 16'h1);
      rd(7'h08, d);
      chk("R4 half flag at 512", d & 16'h0020, 16'h0000);
      chk("R5 not full at 512", d & 16'h0040, 16'h0040);
      push_n(16'h1000 + 16'd512, 512);
      rd(7'h08, d);
      chk("R5 full flag at 1024", d & 16'h0040, 16'h0000);
      push_n(16'hDEAD, 1);
      bad = 0;
      for (int k = 0; k < 1024; k++) begin
         rd(7'h00, d);
         if (d !== 16'h1000 + 16'(k)) begin
            bad++;
            if (bad < 4) $display("FAIL R5 drain %0d actual=%h expected=%h", k, d, 16'h1000 + 16'(k));
         end
      end
      checks++; if (bad != 0) failures++;
      rd(7'h08, d);
      chk("R5 full sticky after drain", d & 16'h00F0, 16'h0020);

      // R6: flush clears sticky full
      wr(7'h0C, 8'h00);
      wr(7'h0C, 8'h04);
      wr(7'h0C, 8'h00);
      rd(7'h08, d);
      chk("R6 flush restores flags", d & 16'h00F0, 16'h0060);

      // R6: incomplete pattern keeps data, full pattern flushes
      push_n(16'h0042, 2);
      wr(7'h0C, 8'h00);
      rd(7'h08, d);
      chk("R6 single zero write keeps data", d & 16'h0010, 16'h0010);
      wr(7'h0C, 8'h04);
      rd(7'h08, d);
      chk("R6 enable high keeps data", d & 16'h0010, 16'h0010);
      wr(7'h0C, 8'h00);
      rd(7'h08, d);
      chk("R6 completed pattern flushes", d & 16'h0010, 16'h0000);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule